// File: doc/BRIEF.md
# Bidirectional LED Running-Light Controller

This block drives an eight-LED bar with a moving light pattern. In single mode, one lit LED sweeps from the top bit of the bar to the bottom bit and back. In pair mode, two lit LEDs start at the outer ends of the bar. They move in mirror image toward the middle, meet at the centre and run back out.

An eight-bit switch value sets how long each pattern is shown. The hold time per step is the switch value plus one, times a base tick of about 10 ms, so one step lasts between about 0.01 s and 2.56 s. Two active-low push-buttons pause and resume the sequence. Each button goes through a two-flop synchronizer, and only a press, seen as a falling edge, acts as a command. A paused sequence keeps its position, its direction and the progress of the current step, and it resumes from that point.

Top module: `led_runner`

## Requirements
- R1: After reset the controller is running. One cycle after reset is released, `led_o` is 8'h80 with `mode_i`=0 (single) or 8'h81 with `mode_i`=1 (pair).
- R2: In single mode, `led_o` shows one lit bit. The lit bit moves one position per step: 7,6,...,0, then 1,...,7, then 6, and so on.
- R3: In pair mode, bits p and 7-p are lit, with p stepping 0,1,2,3,2,1,0,1,... so the patterns run 81,42,24,18,24,42,81 (hex).
- R4: At either end of travel the direction reverses without repeating the end pattern, so each end pattern lasts exactly one step period.
- R5: While running, the pattern changes every (`sw_i`+1)*TICK_DIV clock cycles, where TICK_DIV = CLK_HZ/TICK_HZ. The pattern changes at no other time, except on a mode change.
- R6: A falling edge on the synchronized `stop_ni` (the button reads 0 while pressed) pauses the sequence, and `led_o` then stays unchanged.
- R7: A falling edge on the synchronized `start_ni` resumes a paused sequence. The next pattern shown is the one that follows the held pattern, in the held direction.
- R8: If stop and start edges arrive in the same cycle, stop wins and the sequence is paused.
- R9: A change of `mode_i` restarts the sequence at that mode's start pattern. The next step comes a full step period later.
- R10: With the mode unchanged, `led_o` always has exactly one bit set in single mode and exactly two bits set in pair mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Pattern select: 0 single light, 1 converging pair |
| sw_i | input | 8 | Step period select: (value+1) base ticks per step |
| start_ni | input | 1 | Start button, low while pressed |
| stop_ni | input | 1 | Stop button, low while pressed |
| led_o | output | 8 | LED bar, bit 7 at the top end |

## Verification
The assertions check the following on every cycle. The LED vector has the right number of lit bits for the mode. A single light moves only to an adjacent bit. The pattern changes only on a step strobe or a mode change, and it stays frozen while paused. Stop takes priority over start.

Only the bench scenarios can show the following. The exact order of the patterns in each mode, including the reversal points. The step period measured in cycles for each switch value. The cases where stop and start are pressed together, and the restart after a mode change. Resume is checked at the end of travel, where a lost direction would show.

// File: rtl/led_runner_pkg.sv
package led_runner_pkg;
  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_PAIR   = 1'b1
  } run_mode_e;
endpackage

// File: rtl/led_btn_sync.sv
module led_btn_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_ni,
  output logic fall_o
);
  logic [1:0] sync_q;
  logic       prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], btn_ni};
      prev_q <= sync_q[1];
    end
  end

  assign fall_o = prev_q & ~sync_q[1];
endmodule

// File: rtl/led_step_timer.sv
module led_step_timer #(
  parameter int TICK_DIV = 500000,
  parameter int SW_W     = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            clr_i,
  input  logic [SW_W-1:0] sw_i,
  output logic            step_o
);
  localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(TICK_DIV - 1);

  logic [TW-1:0]   tick_q;
  logic [SW_W-1:0] step_q;
  logic            tick;

  assign tick   = en_i && (tick_q == TICK_LAST);
  // >= so a lowered switch value ends the current step at the next tick
  assign step_o = tick && (step_q >= sw_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
      step_q <= '0;
    end else if (clr_i) begin
      tick_q <= '0;
      step_q <= '0;
    end else if (en_i) begin
      if (tick) begin
        tick_q <= '0;
        step_q <= step_o ? '0 : step_q + 1'b1;
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/led_pos_seq.sv
module led_pos_seq #(
  parameter int NLED = 8,
  localparam int PW  = $clog2(NLED)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pair_i,
  input  logic          restart_i,
  input  logic          step_i,
  output logic [PW-1:0] pos_o
);
  localparam logic [PW-1:0] SINGLE_END = PW'(NLED - 1);
  localparam logic [PW-1:0] PAIR_END   = PW'(NLED / 2 - 1);

  logic [PW-1:0] pos_q;
  logic          back_q;
  logic [PW-1:0] end_pos;

  assign end_pos = pair_i ? PAIR_END : SINGLE_END;
  assign pos_o   = pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      back_q <= 1'b0;
    end else if (restart_i) begin
      pos_q  <= '0;
      back_q <= 1'b0;
    end else if (step_i) begin
      // reverse at ends without repeating the end pattern
      if (!back_q && pos_q == end_pos) begin
        pos_q  <= pos_q - 1'b1;
        back_q <= 1'b1;
      end else if (back_q && pos_q == '0) begin
        pos_q  <= pos_q + 1'b1;
        back_q <= 1'b0;
      end else if (back_q) begin
        pos_q <= pos_q - 1'b1;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/led_runner.sv
module led_runner #(
  parameter int CLK_HZ  = 50000000,
  parameter int TICK_HZ = 100,
  parameter int NLED    = 8,
  parameter int SW_W    = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mode_i,
  input  logic [SW_W-1:0] sw_i,
  input  logic            start_ni,
  input  logic            stop_ni,
  output logic [NLED-1:0] led_o
);
  import led_runner_pkg::*;

  localparam int TICK_DIV = CLK_HZ / TICK_HZ;
  localparam int PW       = $clog2(NLED);

  run_mode_e     mode_q;
  logic          run_q;
  logic          start_fall;
  logic          stop_fall;
  logic          mode_chg;
  logic          step;
  logic [PW-1:0] pos;

  led_btn_sync u_start (.clk_i, .rst_ni, .btn_ni(start_ni), .fall_o(start_fall));
  led_btn_sync u_stop  (.clk_i, .rst_ni, .btn_ni(stop_ni),  .fall_o(stop_fall));

  assign mode_chg = (run_mode_e'(mode_i) != mode_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_SINGLE;
      run_q  <= 1'b1;
    end else begin
      mode_q <= run_mode_e'(mode_i);
      if (stop_fall)       run_q <= 1'b0;
      else if (start_fall) run_q <= 1'b1;
    end
  end

  led_step_timer #(.TICK_DIV(TICK_DIV), .SW_W(SW_W)) u_timer (
    .clk_i, .rst_ni,
    .en_i  (run_q),
    .clr_i (mode_chg),
    .sw_i,
    .step_o(step)
  );

  led_pos_seq #(.NLED(NLED)) u_seq (
    .clk_i, .rst_ni,
    .pair_i   (mode_q == MODE_PAIR),
    .restart_i(mode_chg),
    .step_i   (step),
    .pos_o    (pos)
  );

  // pos 0 is the top bit; pair mode mirrors it from the bottom
  for (genvar i = 0; i < NLED; i++) begin : g_led
    assign led_o[i] = (pos == PW'(NLED - 1 - i)) ||
                      ((mode_q == MODE_PAIR) && (pos == PW'(i)));
  end
endmodule

// File: rtl/led_runner_chk.sv
module led_runner_chk #(
  parameter int NLED = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [NLED-1:0] led_o,
  input logic            mode_q,
  input logic            run_q,
  input logic            step,
  input logic            stop_fall,
  input logic            start_fall
);
  a_r10_single_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q) |-> ($countones(led_o) == 1));

  a_r10_pair_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q |-> ($countones(led_o) == 2));

  a_r2_adjacent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q && !$past(mode_q) && led_o != $past(led_o)) |->
    (led_o == ($past(led_o) << 1) || led_o == ($past(led_o) >> 1)));

  a_r5_change_on_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (led_o != $past(led_o) && mode_q == $past(mode_q)) |-> $past(step));

  a_r6_hold_paused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(run_q) && mode_q == $past(mode_q)) |-> $stable(led_o));

  a_r8_stop_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_fall |=> !run_q);

  a_r7_start_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_fall && !stop_fall) |=> run_q);
endmodule

bind led_runner led_runner_chk #(.NLED(NLED)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .led_o     (led_o),
  .mode_q    (mode_q),
  .run_q     (run_q),
  .step      (step),
  .stop_fall (stop_fall),
  .start_fall(start_fall)
);

// File: tb/led_runner_test.sv
module led_runner_test;
  localparam int CLK_HZ  = 400;
  localparam int TICK_HZ = 100;
  localparam int D       = CLK_HZ / TICK_HZ;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode = 1'b0;
  logic [7:0] sw = 8'd0;
  logic       start_n = 1'b1;
  logic       stop_n = 1'b1;
  logic [7:0] led;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  led_runner #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .sw_i(sw),
    .start_ni(start_n), .stop_ni(stop_n), .led_o(led)
  );

  function automatic logic [7:0] exp_led(input int m, input int k);
    int ph, p;
    if (m == 0) begin
      ph = k % 14; p = (ph < 8) ? ph : 14 - ph;
      return 8'(1 << (7 - p));
    end
    ph = k % 6; p = (ph < 4) ? ph : 6 - ph;
    return 8'((1 << (7 - p)) | (1 << p));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_change(output int cyc, output logic [7:0] v);
    logic [7:0] prev = led;
    cyc = 0;
    do begin
      @(negedge clk); cyc++;
    end while (led == prev && cyc < 5000);
    v = led;
  endtask

  task automatic do_reset(input logic m, input logic [7:0] s);
    @(negedge clk);
    rst_n = 1'b0; mode = m; sw = s; start_n = 1'b1; stop_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic press(input bit st, input bit sp);
    start_n = ~st; stop_n = ~sp;
    repeat (4) @(negedge clk);
    start_n = 1'b1; stop_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int cyc;
    logic [7:0] v, held;
    int sws[4] = '{0, 1, 3, 7};

    // R2 R3 R4 R5: pattern order and period per mode and switch value
    for (int m = 0; m < 2; m++) begin
      foreach (sws[j]) begin
        do_reset(m[0], 8'(sws[j]));
        check(led == exp_led(m, 0), "R1 reset pattern", led, exp_led(m, 0));
        for (int i = 1; i <= 16; i++) begin
          wait_change(cyc, v);
          check(v == exp_led(m, i), m ? "R3/R4 pair order" : "R2/R4 single order", v, exp_led(m, i));
          if (i > 1) check(cyc == (sws[j] + 1) * D, "R5 step period", cyc, (sws[j] + 1) * D);
        end
      end
    end

    // R5: period sweep over switch values, plus the top value
    for (int s = 0; s < 33; s++) begin
      int sv = (s == 32) ? 255 : s;
      do_reset(1'b0, 8'(sv));
      wait_change(cyc, v);
      wait_change(cyc, v);
      check(cyc == (sv + 1) * D, "R5 period sweep", cyc, (sv + 1) * D);
    end

    // R6 R7: pause at the bottom end, resume keeps direction
    do_reset(1'b0, 8'd7);
    for (int i = 1; i <= 7; i++) wait_change(cyc, v);
    check(v == 8'h01, "R2 bottom end", v, 8'h01);
    press(1'b0, 1'b1);
    held = led;
    repeat (100) @(negedge clk);
    check(led == held && held == 8'h01, "R6 paused hold", led, 8'h01);
    press(1'b1, 1'b0);
    wait_change(cyc, v);
    check(v == exp_led(0, 8), "R7 resume next", v, exp_led(0, 8));

    // R8: both pressed together -> paused
    press(1'b1, 1'b1);
    held = led;
    repeat (100) @(negedge clk);
    check(led == held, "R8 stop wins", led, held);
    check(held == exp_led(0, 8), "R8 held pattern", held, exp_led(0, 8));
    press(1'b1, 1'b0);
    wait_change(cyc, v);
    check(v == exp_led(0, 9), "R7 resume after both", v, exp_led(0, 9));

    // R9: mode change restarts with a full period
    do_reset(1'b0, 8'd1);
    wait_change(cyc, v);
    wait_change(cyc, v);
    mode = 1'b1;
    repeat (2) @(negedge clk);
    check(led == 8'h81, "R9 restart pattern", led, 8'h81);
    wait_change(cyc, v);
    check(v == 8'h42, "R9 first step", v, 8'h42);
    check(cyc == 2 * D - 1, "R9 full period", cyc, 2 * D - 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule